// File: doc/BRIEF.md
# Shifted Operand Generator

This block builds the second source operand of a 32-bit RISC data-processing datapath. Its inputs are the instruction word, the value already read from the shifted source register, the value of the shift-amount register, and the current carry flag. It returns the operand, the carry that the shifter produced, and a code that says which operand form the instruction uses.

There are three operand forms. In the first, an 8-bit constant is rotated right. In the second, a register is shifted by a 5-bit amount taken from the instruction. In the third, a register is shifted by an amount held in another register. In the immediate-amount form a zero amount has special meanings: for right shifts it means a shift by 32, and for rotate it means a one-bit rotate through the carry. The operand logic is purely combinational. A parameter adds one output register stage, which carries a valid bit with it.

Top module: `shift_operand_unit`

## Requirements
- R1: The form code is decoded from the instruction. Bits [27:25]=001 gives code 1 (rotated constant). Bits [27:25]=000 with bit 4=0 gives code 2 (immediate-amount shift). Bits [27:25]=000 with bit 7=0 and bit 4=1 gives code 3 (register-amount shift). Any other word gives code 0, with operand 0 and carry equal to the carry input.
- R2: In the rotated-constant form, the constant in bits [7:0] is rotated right by twice the value of bits [11:8]. The carry equals the carry input when that field is 0; otherwise it equals bit 31 of the result.
- R3: In the immediate-amount form, the amount is bits [11:7] and the shift type is bits [6:5], coded 0=LSL, 1=LSR, 2=ASR, 3=ROR. For nonzero amounts the result is the usual shift or rotate, and the carry is the last bit shifted out.
- R4: An immediate LSL by 0 passes the register through unchanged, and the carry equals the carry input.
- R5: An immediate LSR with an amount field of 0 shifts by 32: the result is 0 and the carry is bit 31 of the register.
- R6: An immediate ASR with an amount field of 0 shifts by 32: every result bit is a copy of bit 31, and the carry is bit 31.
- R7: An immediate ROR with an amount field of 0 rotates through the carry. The result is {carry_in, value[31:1]} and the carry is value[0].
- R8: In the register-amount form, the amount is the low 8 bits of the amount register, and its upper 24 bits have no effect. An amount of 0 passes the register through with the carry equal to the carry input.
- R9: A register amount of exactly 32 behaves as follows. LSL gives 0 with carry value[0]. LSR gives 0 with carry value[31]. ASR gives 32 copies of bit 31 with carry value[31]. ROR gives the unchanged value with carry value[31].
- R10: A register amount from 33 to 255 behaves as follows. LSL and LSR give 0 with carry 0. ASR gives 32 copies of bit 31 with carry value[31]. ROR rotates by the amount modulo 32, and when that remainder is 0 it behaves as in R9.
- R11: With the output stage enabled, the result of an input accepted at one clock edge appears after that edge, flagged by out_valid. Reset clears out_valid, operand, carry_out and form to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current inputs as a valid operation |
| instr | input | 32 | Instruction word |
| rm_val | input | XLEN | Value of the register to be shifted |
| rs_val | input | XLEN | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid |
| operand | output | XLEN | Shifted or rotated operand |
| carry_out | output | 1 | Carry produced by the shifter |
| form | output | 2 | Operand form code (0 none, 1 rotated constant, 2 immediate shift, 3 register shift) |

## Verification
The bench targets the zero-amount reinterpretations in the immediate form.
- A design that read a zero LSR or ASR literally would return the register unchanged instead of zero or a sign fill.
- A design that treated a zero ROR as no rotate would lose the injected carry bit.

Register amounts of 32, 33 and 200 are tested, and amounts whose upper bits are set.
- A shifter that keeps only five amount bits would wrap these amounts instead of saturating them.
- A shifter that reads more than eight amount bits would shift when the low byte is zero.

Carry-out is compared on every vector. An off-by-one in the last-bit-out selection, or a rotated constant with rotate 0 that does not pass the carry flag through, shows up as a carry mismatch.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int INSTR_W = 32;

  typedef enum logic [1:0] {
    FORM_NONE   = 2'd0,
    FORM_ROTIMM = 2'd1,
    FORM_IMMSH  = 2'd2,
    FORM_REGSH  = 2'd3
  } sop_form_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sop_shift_e;
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AMTW = 8
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    rs_val,
  output sop_form_e          form,
  output sop_shift_e         sh_type,
  output logic [AMTW-1:0]    sh_amt,
  output logic               rrx,
  output logic [3:0]         rot_field,
  output logic [7:0]         imm8
);
  localparam int IMM_AMT_W = 5;

  logic [IMM_AMT_W-1:0] imm_amt;
  logic                 unused_bits;

  assign imm_amt     = instr[11:7];
  assign rot_field   = instr[11:8];
  assign imm8        = instr[7:0];
  assign sh_type     = sop_shift_e'(instr[6:5]);
  assign unused_bits = ^{instr[31:28], instr[24:12], rs_val[XLEN-1:AMTW]};

  always_comb begin
    form   = FORM_NONE;
    sh_amt = '0;
    rrx    = 1'b0;
    if (instr[27:25] == 3'b001) begin
      form = FORM_ROTIMM;
    end else if (instr[27:25] == 3'b000 && !instr[4]) begin
      form   = FORM_IMMSH;
      sh_amt = AMTW'(imm_amt);
      if (imm_amt == '0) begin
        if (sh_type == SH_LSR || sh_type == SH_ASR) sh_amt = AMTW'(XLEN);
        if (sh_type == SH_ROR) rrx = 1'b1;
      end
    end else if (instr[27:25] == 3'b000 && !instr[7] && instr[4]) begin
      form   = FORM_REGSH;
      sh_amt = rs_val[AMTW-1:0];
    end
  end
endmodule

// File: rtl/sop_barrel.sv
module sop_barrel
  import sop_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AMTW = 8
) (
  input  logic [XLEN-1:0] value,
  input  logic [AMTW-1:0] amt,
  input  sop_shift_e      sh_type,
  input  logic            rrx,
  input  logic            carry_in,
  output logic [XLEN-1:0] result,
  output logic            carry_out
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN:0]   lsl_t, lsr_t, asr_t;
  logic [SHW-1:0]  rot;
  logic [XLEN-1:0] rot_v;

  always_comb begin
    lsl_t = {1'b0, value} << amt;
    lsr_t = {value, 1'b0} >> amt;
    asr_t = $signed({value, 1'b0}) >>> amt;
    rot   = amt[SHW-1:0];
    rot_v = (value >> rot) | (value << (XLEN - int'(rot)));

    result    = value;
    carry_out = carry_in;
    if (rrx) begin
      result    = {carry_in, value[XLEN-1:1]};
      carry_out = value[0];
    end else if (amt != '0) begin
      unique case (sh_type)
        SH_LSL: begin result = lsl_t[XLEN-1:0]; carry_out = lsl_t[XLEN]; end
        SH_LSR: begin result = lsr_t[XLEN:1];   carry_out = lsr_t[0];    end
        SH_ASR: begin result = asr_t[XLEN:1];   carry_out = asr_t[0];    end
        SH_ROR: begin result = rot_v;           carry_out = rot_v[XLEN-1]; end
      endcase
    end
  end
endmodule

// File: rtl/sop_rotimm.sv
module sop_rotimm #(
  parameter int XLEN = 32
) (
  input  logic [7:0]      imm8,
  input  logic [3:0]      rot_field,
  input  logic            carry_in,
  output logic [XLEN-1:0] result,
  output logic            carry_out
);
  localparam int RW = $clog2(XLEN);

  logic [XLEN-1:0] ext;
  logic [RW-1:0]   sh;

  always_comb begin
    ext       = {{(XLEN-8){1'b0}}, imm8};
    sh        = RW'({rot_field, 1'b0});
    result    = (ext >> sh) | (ext << (XLEN - int'(sh)));
    carry_out = (sh == '0) ? carry_in : result[XLEN-1];
  end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import sop_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int AMTW    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [XLEN-1:0]     rm_val,
  input  logic [XLEN-1:0]     rs_val,
  input  logic                carry_in,
  output logic                out_valid,
  output logic [XLEN-1:0]     operand,
  output logic                carry_out,
  output logic [1:0]          form
);
  sop_form_e       form_c;
  sop_shift_e      sh_type;
  logic [AMTW-1:0] sh_amt;
  logic            rrx;
  logic [3:0]      rot_field;
  logic [7:0]      imm8;
  logic [XLEN-1:0] bar_res, rot_res, op_c;
  logic            bar_cy, rot_cy, cy_c;

  sop_decode #(.XLEN(XLEN), .AMTW(AMTW)) u_dec (
    .instr(instr), .rs_val(rs_val), .form(form_c), .sh_type(sh_type),
    .sh_amt(sh_amt), .rrx(rrx), .rot_field(rot_field), .imm8(imm8)
  );

  sop_barrel #(.XLEN(XLEN), .AMTW(AMTW)) u_bar (
    .value(rm_val), .amt(sh_amt), .sh_type(sh_type), .rrx(rrx),
    .carry_in(carry_in), .result(bar_res), .carry_out(bar_cy)
  );

  sop_rotimm #(.XLEN(XLEN)) u_rot (
    .imm8(imm8), .rot_field(rot_field), .carry_in(carry_in),
    .result(rot_res), .carry_out(rot_cy)
  );

  always_comb begin
    unique case (form_c)
      FORM_ROTIMM:          begin op_c = rot_res; cy_c = rot_cy;   end
      FORM_IMMSH, FORM_REGSH: begin op_c = bar_res; cy_c = bar_cy; end
      default:              begin op_c = '0;      cy_c = carry_in; end
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          operand   <= '0;
          carry_out <= 1'b0;
          form      <= '0;
        end else begin
          out_valid <= in_valid;
          operand   <= op_c;
          carry_out <= cy_c;
          form      <= form_c;
        end
      end

      assert_out_stage_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (operand == $past(op_c) && carry_out == $past(cy_c)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign operand   = op_c;
      assign carry_out = cy_c;
      assign form      = form_c;
    end
  endgenerate

  assert_lsr_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (form_c == FORM_IMMSH && instr[6:5] == 2'd1 && instr[11:7] == 5'd0)
      |-> (op_c == '0 && cy_c == rm_val[XLEN-1]));

  assert_asr_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (form_c == FORM_IMMSH && instr[6:5] == 2'd2 && instr[11:7] == 5'd0)
      |-> (op_c == {XLEN{rm_val[XLEN-1]}} && cy_c == rm_val[XLEN-1]));

  assert_rrx_R7: assert property (@(posedge clk) disable iff (rst)
    (form_c == FORM_IMMSH && instr[6:5] == 2'd3 && instr[11:7] == 5'd0)
      |-> (op_c == {carry_in, rm_val[XLEN-1:1]} && cy_c == rm_val[0]));

  assert_reg_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (form_c == FORM_REGSH && rs_val[AMTW-1:0] == '0)
      |-> (op_c == rm_val && cy_c == carry_in));

  assert_rot_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (form_c == FORM_ROTIMM && instr[11:8] == 4'd0)
      |-> (op_c == XLEN'(instr[7:0]) && cy_c == carry_in));
endmodule

// File: tb/sim_shift_operand_unit.sv
module sim_shift_operand_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, rm_val = '0, rs_val = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, carry_out;
  logic [31:0] operand;
  logic [1:0]  form;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] op;
    logic        cy;
    logic [1:0]  f;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  shift_operand_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .rm_val(rm_val),
    .rs_val(rs_val), .carry_in(carry_in), .out_valid(out_valid),
    .operand(operand), .carry_out(carry_out), .form(form)
  );

  // Bit-serial reference: one position per step, carry is the last bit to leave
  function automatic void shift_steps(input logic [1:0] t, input int n,
                                      inout logic [31:0] v, inout logic c);
    for (int i = 0; i < n; i++) begin
      case (t)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
  endfunction

  function automatic exp_t model(input logic [31:0] ins, input logic [31:0] rm,
                                 input logic [31:0] rs, input logic cin, input string tag);
    exp_t e;
    logic [31:0] v;
    logic c;
    int n;
    e.tag = tag;
    c = cin;
    if (ins[27:25] == 3'b001) begin
      v = {24'd0, ins[7:0]};
      shift_steps(2'd3, 2 * int'(ins[11:8]), v, c);
      e.f = 2'd1;
    end else if (ins[27:25] == 3'b000 && !ins[4]) begin
      v = rm;
      n = int'(ins[11:7]);
      if (n == 0 && ins[6:5] == 2'd3) begin
        c = rm[0];
        v = {cin, rm[31:1]};
      end else begin
        if (n == 0 && (ins[6:5] == 2'd1 || ins[6:5] == 2'd2)) n = 32;
        shift_steps(ins[6:5], n, v, c);
      end
      e.f = 2'd2;
    end else if (ins[27:25] == 3'b000 && !ins[7] && ins[4]) begin
      v = rm;
      shift_steps(ins[6:5], int'(rs[7:0]), v, c);
      e.f = 2'd3;
    end else begin
      v = '0;
      e.f = 2'd0;
    end
    e.op = v;
    e.cy = c;
    return e;
  endfunction

  function automatic logic [31:0] imm_sh(input logic [1:0] t, input logic [4:0] a);
    return {4'hE, 3'b000, 4'h4, 1'b0, 4'h1, 4'h2, a, t, 1'b0, 4'h3};
  endfunction
  function automatic logic [31:0] reg_sh(input logic [1:0] t);
    return {4'hE, 3'b000, 4'hD, 1'b1, 4'h1, 4'h2, 4'h5, 1'b0, t, 1'b1, 4'h3};
  endfunction
  function automatic logic [31:0] rot_imm(input logic [3:0] r, input logic [7:0] k);
    return {4'hE, 3'b001, 4'hD, 1'b0, 4'h0, 4'h2, r, k};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [31:0] rm,
                      input logic [31:0] rs, input logic cin, input string tag);
    @(negedge clk);
    instr = ins; rm_val = rm; rs_val = rs; carry_in = cin; in_valid = 1'b1;
    sb.push_back(model(ins, rm, rs, cin, tag));
  endtask

  // Monitor: results show up just after the edge that captured them
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected out_valid operand %h exp none", operand);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (operand !== e.op || carry_out !== e.cy || form !== e.f) begin
            errors++;
            $display("FAIL %s operand %h exp %h carry %b exp %b form %0d exp %0d",
                     e.tag, operand, e.op, carry_out, e.cy, form, e.f);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7F3C_A5E1;
    pats[2] = 32'hC001_0FF0;
    pats[3] = 32'h0000_0002;

    // R11: reset state, with in_valid held high during reset
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || operand !== '0 || carry_out !== 1'b0 || form !== 2'd0) begin
      errors++;
      $display("FAIL R11 reset outputs %b/%h/%b/%0d exp 0/0/0/0",
               out_valid, operand, carry_out, form);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    for (int p = 0; p < 4; p++) begin
      for (int ci = 0; ci < 2; ci++) begin
        // R3 R4 R5 R6 R7: immediate-amount form
        send(imm_sh(2'd0, 5'd0),  pats[p], 32'h0, ci[0], "R4 lsl#0");
        send(imm_sh(2'd0, 5'd1),  pats[p], 32'h0, ci[0], "R3 lsl#1");
        send(imm_sh(2'd0, 5'd31), pats[p], 32'h0, ci[0], "R3 lsl#31");
        send(imm_sh(2'd1, 5'd0),  pats[p], 32'h0, ci[0], "R5 lsr#0=32");
        send(imm_sh(2'd1, 5'd1),  pats[p], 32'h0, ci[0], "R3 lsr#1");
        send(imm_sh(2'd1, 5'd31), pats[p], 32'h0, ci[0], "R3 lsr#31");
        send(imm_sh(2'd2, 5'd0),  pats[p], 32'h0, ci[0], "R6 asr#0=32");
        send(imm_sh(2'd2, 5'd1),  pats[p], 32'h0, ci[0], "R3 asr#1");
        send(imm_sh(2'd2, 5'd31), pats[p], 32'h0, ci[0], "R3 asr#31");
        send(imm_sh(2'd3, 5'd0),  pats[p], 32'h0, ci[0], "R7 rrx");
        send(imm_sh(2'd3, 5'd1),  pats[p], 32'h0, ci[0], "R3 ror#1");
        send(imm_sh(2'd3, 5'd13), pats[p], 32'h0, ci[0], "R3 ror#13");
        // R8 R9 R10: register-amount form
        for (int t = 0; t < 4; t++) begin
          send(reg_sh(t[1:0]), pats[p], 32'd0,         ci[0], "R8 reg amt 0");
          send(reg_sh(t[1:0]), pats[p], 32'hFFFF_FF00, ci[0], "R8 upper bits ignored");
          send(reg_sh(t[1:0]), pats[p], 32'd1,         ci[0], "R8 reg amt 1");
          send(reg_sh(t[1:0]), pats[p], 32'd31,        ci[0], "R8 reg amt 31");
          send(reg_sh(t[1:0]), pats[p], 32'hABCD_0120, ci[0], "R9 reg amt 32");
          send(reg_sh(t[1:0]), pats[p], 32'd33,        ci[0], "R10 reg amt 33");
          send(reg_sh(t[1:0]), pats[p], 32'd64,        ci[0], "R10 reg amt 64");
          send(reg_sh(t[1:0]), pats[p], 32'd200,       ci[0], "R10 reg amt 200");
        end
        // R2: rotated constant
        send(rot_imm(4'd0,  pats[p][7:0]), 32'h0, 32'h0, ci[0], "R2 rot 0");
        send(rot_imm(4'd1,  pats[p][7:0]), 32'h0, 32'h0, ci[0], "R2 rot 1");
        send(rot_imm(4'd4,  pats[p][7:0]), 32'h0, 32'h0, ci[0], "R2 rot 4");
        send(rot_imm(4'd15, pats[p][7:0]), 32'h0, 32'h0, ci[0], "R2 rot 15");
        // R1: non-operand encodings
        send({4'hE, 3'b000, 9'h012, 8'h00, 4'h9, 4'h3}, pats[p], 32'd4, ci[0], "R1 bit7&bit4 none");
        send({4'hE, 3'b010, 9'h012, 16'h1234}, pats[p], 32'd4, ci[0], "R1 load form none");
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R11: every issued item came back exactly once
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 pending results %0d exp 0", sb.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule